// File: doc/BRIEF.md
# Phase-Synchronized PWM Channel

This block is one PWM output channel on an up-counting time base. A counter runs from zero to a programmed period and wraps. An action stage drives output A from three events: counter at zero, counter equal to the active compare-A value, and a third event, T1, whose source can be chosen. Each event carries its own two-bit action code.

Several channels can be chained. One channel emits a sync pulse, and the next channel uses that pulse as sync-in. When phase loading is enabled, sync-in forces the counter to a programmed phase value. If that value lies beyond compare A, the jump skips the compare-A match, and output A would stay high for the rest of the period. Routing T1 from sync-in with a clear action restores the lost edge at the moment of the jump. The channel's own sync-out source is selectable. Compare values are shadowed, so mid-period updates never split a pulse.

Top module: `pwm_phase_chan`

## Requirements
- R1: The counter advances by one per clock from 0 up to `period`. On the clock after it equals `period` it returns to 0, so a full cycle lasts `period`+1 clocks.
- R2: Action codes for `act_zero`, `act_cmpa` and `act_t1`:
  - 2'b00 leaves output A unchanged.
  - 2'b01 drives it low.
  - 2'b10 drives it high.
  - 2'b11 inverts it.
  
  Output A is registered. An event seen on a clock edge changes `out_a` right after that edge. With zero=set and compare-A=clear, `out_a` is high for exactly `cmpa` clocks per cycle.
- R3: When `phase_en` is 1, a `sync_in` high on a clock edge loads `phase` into the counter at that edge. When `phase_en` is 0, `sync_in` leaves the counter untouched.
- R4: `t1_src` selects the T1 event:
  - 2'b00: no T1 event.
  - 2'b01: `sync_in`.
  - 2'b10: counter equal to active compare B.
  - 2'b11: no T1 event.
  
  With T1 taken from `sync_in` and `act_t1`=clear, a phase jump past compare A drives `out_a` low at the jump. With no T1 event, `out_a` stays high through the wrap.
- R5: When several events occur on the same edge, only the highest-priority event whose code is not 2'b00 acts. The order is T1 first, then compare A, then zero.
- R6: `cmpa` and `cmpb` are copied into the active compare values on each edge where the counter is 0, and throughout reset. A change at any other time takes effect from the next counter zero.
- R7: `sync_sel` selects the sync-out source:
  - 2'b00: off.
  - 2'b01: counter zero.
  - 2'b10: counter equal to active compare B.
  - 2'b11: `sync_in` passed through.
  
  `sync_out` is registered and goes high for one clock, right after the edge on which the source is seen.
- R8: `ctr_init` high on an edge loads `ctr_start` into the counter and forces `out_a` low. It takes precedence over phase load, wrap and all actions.
- R9: While `rst_n` is low, on each clock edge the counter is set to 0 and `out_a` and `sync_out` are set low.
- R10: A compare-A value of 0 keeps `out_a` low, because the clear wins over the zero set. A compare-A value above `period` never matches, so `out_a` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctr_init | input | 1 | Load counter with start value, force output low |
| ctr_start | input | CW | Counter start value |
| period | input | CW | Last count before wrap |
| cmpa | input | CW | Compare A shadow value |
| cmpb | input | CW | Compare B shadow value |
| phase | input | CW | Counter value loaded on sync |
| phase_en | input | 1 | Enables phase load on sync-in |
| sync_in | input | 1 | Sync pulse from the preceding channel |
| act_zero | input | 2 | Action on counter zero |
| act_cmpa | input | 2 | Action on compare-A match |
| act_t1 | input | 2 | Action on T1 event |
| t1_src | input | 2 | T1 event source select |
| sync_sel | input | 2 | Sync-out source select |
| out_a | output | 1 | PWM output A |
| sync_out | output | 1 | Sync pulse to the following channel |

## Verification
A counter that holds a wrong value shows up at `out_a` as a misplaced set or clear edge within one cycle of `period`+1 clocks. The bench therefore checks edges at exact clock offsets from a counter-init, not just duty totals. A phase load that is taken when it should be ignored, or the reverse, moves the compare-A clear to a different clock within the same cycle. A stale active compare value appears as an edge one cycle early or late around the next counter zero. Sync-out errors appear one clock after the source event.

// File: rtl/pwm_sync_pkg.sv
// Shared encodings for the phase-synchronized PWM channel.
// Assumes 2-bit code fields on all selector ports.
package pwm_sync_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        T1_OFF   = 2'b00,
        T1_SYNC  = 2'b01,
        T1_CMPB  = 2'b10,
        T1_OFF2  = 2'b11
    } t1_src_e;

    typedef enum logic [1:0] {
        SO_OFF   = 2'b00,
        SO_ZERO  = 2'b01,
        SO_CMPB  = 2'b10,
        SO_PASS  = 2'b11
    } so_sel_e;

    // Event indices; a higher index has higher priority
    localparam int EV_ZERO = 0;
    localparam int EV_CMPA = 1;
    localparam int EV_T1   = 2;
    localparam int NEV     = 3;

endpackage

// File: rtl/pwm_tbase.sv
// Up-counting time base with phase load on sync and a counter-init.
// Priority: reset, init, phase load, wrap, increment.
// Assumes period fits in CW bits; a phase above period wraps on the next edge.
module pwm_tbase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctr_init,
    input  logic [CW-1:0] ctr_start,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] phase,
    input  logic          phase_en,
    input  logic          sync_in,
    output logic [CW-1:0] cnt,
    output logic          at_zero
);

    logic phase_load;

    // Qualify sync-in by the phase enable
    always_comb phase_load = phase_en && sync_in;

    // Counter update
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ctr_init)
            cnt <= ctr_start;
        else if (phase_load)
            cnt <= phase;
        else if (cnt >= period)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Zero flag for shadow load and events
    always_comb at_zero = (cnt == '0);

endmodule

// File: rtl/pwm_cmp_shadow.sv
// Shadow-to-active copy for NCMP compare values, taken at counter zero.
// During reset the active values follow the inputs, so the first cycle
// after reset already uses the programmed compares.
module pwm_cmp_shadow #(
    parameter int CW   = 16,
    parameter int NCMP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      at_zero,
    input  logic [NCMP-1:0][CW-1:0]   shd,
    output logic [NCMP-1:0][CW-1:0]   act_q
);

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        // Copy one shadow value when the counter is at zero
        always_ff @(posedge clk) begin
            if (!rst_n || at_zero)
                act_q[g] <= shd[g];
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
// Action qualifier: applies the action of the highest-priority event that
// fires with a code other than "none". Higher event index wins.
// A counter-init forces the output low.
module pwm_action_qual
    import pwm_sync_pkg::*;
#(
    parameter int N = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctr_init,
    input  logic [N-1:0]       ev,
    input  logic [N-1:0][1:0]  act,
    output logic               out_q
);

    logic out_nxt;
    logic taken;

    // Resolve events by priority
    always_comb begin
        out_nxt = out_q;
        taken   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!taken && ev[i] && (act_e'(act[i]) != ACT_NONE)) begin
                taken = 1'b1;
                case (act_e'(act[i]))
                    ACT_CLR: out_nxt = 1'b0;
                    ACT_SET: out_nxt = 1'b1;
                    ACT_TGL: out_nxt = ~out_q;
                    default: out_nxt = out_q;
                endcase
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n || ctr_init)
            out_q <= 1'b0;
        else
            out_q <= out_nxt;
    end

endmodule

// File: rtl/pwm_sync_gen.sv
// Sync-out source select with a registered one-clock output.
module pwm_sync_gen
    import pwm_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       at_zero,
    input  logic       cmpb_hit,
    input  logic       sync_in,
    output logic       sync_out
);

    logic src;

    // Pick the sync-out source
    always_comb begin
        case (so_sel_e'(sel))
            SO_ZERO: src = at_zero;
            SO_CMPB: src = cmpb_hit;
            SO_PASS: src = sync_in;
            default: src = 1'b0;
        endcase
    end

    // Register the pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_out <= 1'b0;
        else
            sync_out <= src;
    end

endmodule

// File: rtl/pwm_phase_chan.sv
// Phase-synchronized PWM channel: time base, shadowed compares, action
// qualifier with a selectable T1 event, and sync-out generation.
// Assumes single-clock operation and synchronous inputs.
module pwm_phase_chan
    import pwm_sync_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctr_init,
    input  logic [CW-1:0] ctr_start,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cmpa,
    input  logic [CW-1:0] cmpb,
    input  logic [CW-1:0] phase,
    input  logic          phase_en,
    input  logic          sync_in,
    input  logic [1:0]    act_zero,
    input  logic [1:0]    act_cmpa,
    input  logic [1:0]    act_t1,
    input  logic [1:0]    t1_src,
    input  logic [1:0]    sync_sel,
    output logic          out_a,
    output logic          sync_out
);

    localparam int NCMP = 2;

    logic [CW-1:0]            cnt;
    logic                     at_zero;
    logic [NCMP-1:0][CW-1:0]  cmp_shd;
    logic [NCMP-1:0][CW-1:0]  cmp_act;
    logic                     cmpa_hit;
    logic                     cmpb_hit;
    logic                     t1_ev;
    logic [NEV-1:0]           ev;
    logic [NEV-1:0][1:0]      act;

    pwm_tbase #(.CW(CW)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctr_init  (ctr_init),
        .ctr_start (ctr_start),
        .period    (period),
        .phase     (phase),
        .phase_en  (phase_en),
        .sync_in   (sync_in),
        .cnt       (cnt),
        .at_zero   (at_zero)
    );

    // Pack the shadow compare inputs
    always_comb begin
        cmp_shd[0] = cmpa;
        cmp_shd[1] = cmpb;
    end

    pwm_cmp_shadow #(.CW(CW), .NCMP(NCMP)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .at_zero (at_zero),
        .shd     (cmp_shd),
        .act_q   (cmp_act)
    );

    // Compare matches against the active values
    always_comb begin
        cmpa_hit = (cnt == cmp_act[0]);
        cmpb_hit = (cnt == cmp_act[1]);
    end

    // T1 event source select
    always_comb begin
        case (t1_src_e'(t1_src))
            T1_SYNC: t1_ev = sync_in;
            T1_CMPB: t1_ev = cmpb_hit;
            default: t1_ev = 1'b0;
        endcase
    end

    // Event and action vectors in priority order
    always_comb begin
        ev[EV_ZERO]  = at_zero;
        ev[EV_CMPA]  = cmpa_hit;
        ev[EV_T1]    = t1_ev;
        act[EV_ZERO] = act_zero;
        act[EV_CMPA] = act_cmpa;
        act[EV_T1]   = act_t1;
    end

    pwm_action_qual #(.N(NEV)) u_aq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctr_init (ctr_init),
        .ev       (ev),
        .act      (act),
        .out_q    (out_a)
    );

    pwm_sync_gen u_so (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sync_sel),
        .at_zero  (at_zero),
        .cmpb_hit (cmpb_hit),
        .sync_in  (sync_in),
        .sync_out (sync_out)
    );

endmodule

// File: rtl/pwm_phase_chan_chk.sv
// Property checker for pwm_phase_chan, attached by bind.
module pwm_phase_chan_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctr_init,
    input logic [CW-1:0] ctr_start,
    input logic [CW-1:0] period,
    input logic [CW-1:0] phase,
    input logic          phase_en,
    input logic          sync_in,
    input logic [1:0]    act_t1,
    input logic [1:0]    t1_src,
    input logic [1:0]    sync_sel,
    input logic          out_a,
    input logic          sync_out,
    input logic [CW-1:0] cnt
);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_init && !(phase_en && sync_in) && cnt >= period) |=> (cnt == '0));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_init && !(phase_en && sync_in) && cnt < period) |=> (cnt == $past(cnt) + 1'b1));

    // R3
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_init && phase_en && sync_in) |=> (cnt == $past(phase)));

    // R4
    t1_sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_init && t1_src == 2'b01 && sync_in && act_t1 == 2'b01) |=> !out_a);

    // R7
    sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel == 2'b11 && sync_in) |=> sync_out);

    // R7
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel == 2'b00) |=> !sync_out);

    // R8
    ctr_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_init |=> (cnt == $past(ctr_start) && !out_a));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !out_a && !sync_out));

endmodule

bind pwm_phase_chan pwm_phase_chan_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctr_init  (ctr_init),
    .ctr_start (ctr_start),
    .period    (period),
    .phase     (phase),
    .phase_en  (phase_en),
    .sync_in   (sync_in),
    .act_t1    (act_t1),
    .t1_src    (t1_src),
    .sync_sel  (sync_sel),
    .out_a     (out_a),
    .sync_out  (sync_out),
    .cnt       (cnt)
);

// File: tb/sim_pwm_phase_chan.sv
module sim_pwm_phase_chan;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctr_init;
    logic [CW-1:0] ctr_start, period, cmpa, cmpb, phase;
    logic          phase_en, sync_in;
    logic [1:0]    act_zero, act_cmpa, act_t1, t1_src, sync_sel;
    logic          out_a, sync_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_phase_chan #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctr_init(ctr_init), .ctr_start(ctr_start),
        .period(period), .cmpa(cmpa), .cmpb(cmpb), .phase(phase),
        .phase_en(phase_en), .sync_in(sync_in), .act_zero(act_zero),
        .act_cmpa(act_cmpa), .act_t1(act_t1), .t1_src(t1_src),
        .sync_sel(sync_sel), .out_a(out_a), .sync_out(sync_out)
    );

    // Rows: period, compare A, expected high clocks per cycle
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{9, 4, 4}, '{9, 0, 0}, '{9, 9, 9}, '{9, 12, 10}, '{5, 3, 3}, '{30, 1, 1}
    };

    // Advance past the next rising edge and settle mid-cycle
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse counter-init for one edge; afterwards counter = ctr_start
    task automatic do_init(input int start);
        ctr_start = CW'(start);
        ctr_init  = 1'b1;
        tick();
        ctr_init  = 1'b0;
    endtask

    task automatic defaults();
        period = 16'd19; cmpa = 16'd10; cmpb = 16'd3; phase = 16'd15;
        phase_en = 1'b0; sync_in = 1'b0;
        act_zero = 2'b10; act_cmpa = 2'b01; act_t1 = 2'b00;
        t1_src = 2'b00; sync_sel = 2'b00; ctr_start = '0; ctr_init = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        defaults();
        rst_n = 1'b0;
        #5;
        tick(2);
        // R9 reset state
        chk("R9 out_a in reset", out_a, 0);
        chk("R9 sync_out in reset", sync_out, 0);
        rst_n = 1'b1;

        // R1 R2 R10 table of duty per cycle
        for (int v = 0; v < NV; v++) begin
            int hi;
            period = CW'(VEC[v][0]);
            cmpa   = CW'(VEC[v][1]);
            do_init(0);
            tick(2 * (VEC[v][0] + 1));
            hi = 0;
            for (int c = 0; c <= VEC[v][0]; c++) begin
                hi += int'(out_a);
                tick();
            end
            chk($sformatf("R1/R2/R10 vec%0d high clocks", v), hi, VEC[v][2]);
        end

        // R8 init with start value 7: out low, set seen at edge 14
        defaults();
        do_init(7);
        chk("R8 out low after init", out_a, 0);
        tick(13);
        chk("R8 still low before zero", out_a, 0);
        tick();
        chk("R8 set after counter reached zero", out_a, 1);

        // R3/R4 phase jump past compare A, no T1: pulse extended
        defaults();
        phase_en = 1'b1;
        do_init(0);
        tick(5);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R4 no T1: high after jump", out_a, 1);
        tick(4);
        chk("R4 no T1: still high at wrap", out_a, 1);

        // R4 phase jump with T1 from sync-in clearing
        defaults();
        phase_en = 1'b1; t1_src = 2'b01; act_t1 = 2'b01;
        do_init(0);
        tick(5);
        chk("R4 high before jump", out_a, 1);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R4 T1 clears at jump", out_a, 0);
        tick(5);
        chk("R4 stays low to wrap", out_a, 0);
        tick();
        chk("R3 jumped counter sets at edge 12", out_a, 1);

        // R3 phase disabled: sync ignored, clear at edge 11
        defaults();
        do_init(0);
        tick(5);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        tick(4);
        chk("R3 ignored sync: high at edge 10", out_a, 1);
        tick();
        chk("R3 ignored sync: clear at edge 11", out_a, 0);

        // R5 T1 set beats compare-A clear on same edge
        defaults();
        t1_src = 2'b01; act_t1 = 2'b10;
        do_init(0);
        tick(10);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R5 T1 wins over compare A", out_a, 1);
        // R5 T1 with code none does not block compare A
        act_t1 = 2'b00;
        do_init(0);
        tick(10);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R5 none-coded T1 yields to compare A", out_a, 0);

        // R6 compare A change mid-cycle applies after next zero
        defaults();
        do_init(0);
        tick(3);
        cmpa = 16'd5;
        tick(3);
        chk("R6 old compare kept at edge 6", out_a, 1);
        tick(5);
        chk("R6 old compare clears at edge 11", out_a, 0);
        tick(14);
        chk("R6 new compare high at edge 25", out_a, 1);
        tick();
        chk("R6 new compare clears at edge 26", out_a, 0);

        // R7 sync-out on compare B (=3)
        defaults();
        sync_sel = 2'b10;
        do_init(0);
        tick(3);
        chk("R7 cmpb sync low before", sync_out, 0);
        tick();
        chk("R7 cmpb sync pulse", sync_out, 1);
        tick();
        chk("R7 cmpb sync one clock", sync_out, 0);

        // R7 sync-out on counter zero
        sync_sel = 2'b01;
        do_init(0);
        tick();
        chk("R7 zero sync pulse", sync_out, 1);
        tick();
        chk("R7 zero sync one clock", sync_out, 0);

        // R7 pass-through
        sync_sel = 2'b11;
        tick(2);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R7 pass-through pulse", sync_out, 1);
        tick();
        chk("R7 pass-through one clock", sync_out, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule